// File: doc/BRIEF.md
# Paged Control and Interrupt Register Bank

This block is the host-facing register file of a small Ethernet controller. The host reaches it over an 8-bit bus that has a 4-bit offset, a write strobe and a read strobe. Offset 0 always holds the command byte. Every other offset reaches a register in one of several banks, and bits 7:6 of the command byte pick the bank. The block holds the interrupt status and enable bytes and drives one level-sensitive interrupt line. It also stores the station address, the multicast hash filter and the current receive page.

The receive path, the remote DMA engine and the reset strobe reach the block through side-band ports. They set status bits, move the current receive page and reload the status byte. When the host writes a start-transmit command, the block sends a one-cycle request to the frame sender with the transmit page and byte count. It then records a successful transmit status.

Top module: `ctl_regbank`

## Requirements
- R1: After a synchronous reset the command byte reads 0x01 (stop set, bank 0), interrupt status reads 0x80, the transmit status reads 0x00, `irq` is low and `tx_req` is low.
- R2: Offset 0 is the command byte in every bank. For offsets 1..15, command bits 7:6 select the bank: bank 0 is the control bank, bank 1 is the address bank, and banks 2 and 3 ignore writes. Every read of an undefined register returns 0x00. In bank 0: offset 4 writes the transmit page and reads the transmit status, offsets 5/6 write the low/high transmit count byte, offset 7 reads and clears status, offsets 10/11 write the low/high remote byte count, and offset 15 writes the interrupt enable.
- R3: A write to bank 0 offset 7 clears each status bit 6:0 that is written as 1. It leaves the other bits of 6:0 alone and never changes bit 7.
- R4: `irq` is high exactly when (status AND enable AND 0x7F) is nonzero. It follows the registers in the cycle after any change, so status bit 7 (reset done) can never raise it.
- R5: A command write with bit 0 (stop) clear clears status bit 7. A command write with bit 0 set leaves status bit 7 as it is.
- R6: A command write with bit 0 clear and bit 3 (remote read) or bit 4 (remote write) set sets status bit 6 if the stored remote byte count is zero.
- R7: A command write with bit 0 clear and bit 2 (transmit) set pulses `tx_req` for exactly one cycle. During that pulse `tx_page` and `tx_count` hold the stored transmit page and count. The same write sets the transmit status to 0x01 and sets status bit 1, and the stored command byte has bit 2 cleared.
- R8: A pulse on `rst_port_rd` loads the status byte with 0x80. This takes priority over every other status update in that cycle.
- R9: Each bit set on `evt_set[6:0]` sets the matching status bit. A set wins over a host clear of the same bit in the same cycle.
- R10: Read data appears on `bus_rdata` in the cycle after the read strobe and holds its value until the next read. It reflects the register contents before any write in the same cycle.
- R11: Bank 1 offsets 1..6 hold the station address (offset 1 is bits 7:0 of `sta_addr`), offset 7 holds the current receive page and offsets 8..15 hold the hash filter (offset 8 is bits 7:0 of `mcast_hash`). All of them are readable and writable. A `rx_page_we` pulse loads `rx_page` into the current receive page and wins over a host write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| rst_port_rd | input | 1 | Reset-port read strobe |
| irq | output | 1 | Level interrupt |
| tx_req | output | 1 | One-cycle transmit request |
| tx_page | output | 8 | Transmit start page for the request |
| tx_count | output | 16 | Transmit byte count for the request |
| rdma_count | output | 16 | Stored remote byte count |
| rdma_rd | output | 1 | Remote read requested (command bit 3) |
| rdma_wr | output | 1 | Remote write requested (command bit 4) |
| evt_set | input | 7 | Status set events from receive and DMA logic |
| rx_page_we | input | 1 | Load current receive page |
| rx_page | input | 8 | New current receive page |
| sta_addr | output | 48 | Station address |
| mcast_hash | output | 64 | Multicast hash filter |
| cur_page | output | 8 | Current receive page |

## Verification
A register write takes effect at the clock edge that samples the strobe. The interrupt line, the status read-back and the transmit request are therefore visible one cycle after the write, and the request is gone again one cycle later. Read data is due one cycle after the read strobe. The bench drives strobes on the falling edge and samples on the next falling edge, which is exactly one rising edge later. It compares the results against a reference model that it updates at the moment it issues each stimulus.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
    localparam int DATA_W = 8;
    localparam int OFF_W  = 4;
    localparam int CNT_W  = 2 * DATA_W;

    // command bits
    localparam int CB_STOP = 0;
    localparam int CB_TX   = 2;
    localparam int CB_RRD  = 3;
    localparam int CB_RWR  = 4;

    // status bits
    localparam int SB_TXOK = 1;
    localparam int SB_RDC  = 6;
    localparam int SB_RST  = 7;

    localparam logic [DATA_W-1:0] CMD_AT_RESET  = 8'h01;
    localparam logic [DATA_W-1:0] STAT_AT_RESET = 8'h80;
    localparam logic [DATA_W-1:0] TX_DONE_CODE  = 8'h01;
    localparam logic [DATA_W-1:0] IRQ_FIELD     = 8'h7F;

    // bank 0 offsets
    localparam logic [OFF_W-1:0] B0_TXPG  = 4'h4;
    localparam logic [OFF_W-1:0] B0_TCLO  = 4'h5;
    localparam logic [OFF_W-1:0] B0_TCHI  = 4'h6;
    localparam logic [OFF_W-1:0] B0_STAT  = 4'h7;
    localparam logic [OFF_W-1:0] B0_RCLO  = 4'hA;
    localparam logic [OFF_W-1:0] B0_RCHI  = 4'hB;
    localparam logic [OFF_W-1:0] B0_MASK  = 4'hF;

    typedef enum logic [1:0] {
        BANK_CTRL = 2'd0,
        BANK_ADDR = 2'd1,
        BANK_NONE2 = 2'd2,
        BANK_NONE3 = 2'd3
    } bank_e;
endpackage

// File: rtl/ctl_cmd.sv
module ctl_cmd
    import ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic              b0_we,
    input  logic [OFF_W-1:0]  b0_off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cmd_o,
    output logic [DATA_W-1:0] tsr_o,
    output logic              tx_req_o,
    output logic [DATA_W-1:0] tx_page_o,
    output logic [CNT_W-1:0]  tx_count_o,
    output logic [CNT_W-1:0]  rcount_o,
    output logic              rdc_set_o,
    output logic              txok_set_o,
    output logic              rstdone_clr_o
);
    typedef struct packed {
        logic [DATA_W-1:0] cmd;
        logic [DATA_W-1:0] tsr;
        logic [DATA_W-1:0] tpg;
        logic [CNT_W-1:0]  tcnt;
        logic [CNT_W-1:0]  rcnt;
        logic              req;
        logic [DATA_W-1:0] req_pg;
        logic [CNT_W-1:0]  req_cnt;
    } cmd_st_t;

    cmd_st_t st_d, st_q;
    logic    go;

    always_comb begin
        go            = cmd_we && !wdata[CB_STOP];
        rstdone_clr_o = go;
        rdc_set_o     = go && (wdata[CB_RRD] || wdata[CB_RWR]) && (st_q.rcnt == '0);
        txok_set_o    = go && wdata[CB_TX];

        st_d     = st_q;
        st_d.req = 1'b0;
        if (cmd_we) begin
            st_d.cmd = wdata;
            if (go && wdata[CB_TX]) begin
                st_d.cmd[CB_TX] = 1'b0;
                st_d.tsr        = TX_DONE_CODE;
                st_d.req        = 1'b1;
                st_d.req_pg     = st_q.tpg;
                st_d.req_cnt    = st_q.tcnt;
            end
        end
        if (b0_we) begin
            unique case (b0_off)
                B0_TXPG: st_d.tpg = wdata;
                B0_TCLO: st_d.tcnt[DATA_W-1:0] = wdata;
                B0_TCHI: st_d.tcnt[CNT_W-1:DATA_W] = wdata;
                B0_RCLO: st_d.rcnt[DATA_W-1:0] = wdata;
                B0_RCHI: st_d.rcnt[CNT_W-1:DATA_W] = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= '0;
            st_q.cmd <= CMD_AT_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o      = st_q.cmd;
    assign tsr_o      = st_q.tsr;
    assign tx_req_o   = st_q.req;
    assign tx_page_o  = st_q.req_pg;
    assign tx_count_o = st_q.req_cnt;
    assign rcount_o   = st_q.rcnt;

    // R7: the request lasts one cycle only
    p_tx_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        st_q.req |=> !st_q.req);
    // R7: a stored command never keeps the transmit bit next to a request
    p_tx_clears_bit_r7: assert property (@(posedge clk) disable iff (rst)
        st_q.req |-> !st_q.cmd[CB_TX]);
endmodule

// File: rtl/ctl_irq.sv
module ctl_irq
    import ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stat_we,
    input  logic              mask_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [6:0]        set_bits,
    input  logic              rstdone_clr,
    input  logic              load_reset,
    output logic [DATA_W-1:0] stat_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] mask;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stat_we)
            st_d.stat[6:0] = st_q.stat[6:0] & ~wdata[6:0];
        if (rstdone_clr)
            st_d.stat[SB_RST] = 1'b0;
        st_d.stat[6:0] = st_d.stat[6:0] | set_bits;
        if (mask_we)
            st_d.mask = wdata;
        if (load_reset)
            st_d.stat = STAT_AT_RESET;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.stat <= STAT_AT_RESET;
            st_q.mask <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;
    assign irq_o  = |(st_q.stat & st_q.mask & IRQ_FIELD);

    // R3: bits written as one are gone unless something sets them again
    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (stat_we && !load_reset && set_bits == '0)
        |=> (st_q.stat[6:0] & $past(wdata[6:0])) == '0);
    // R3: a status write leaves the reset-done bit alone
    p_bit7_kept_r3: assert property (@(posedge clk) disable iff (rst)
        (stat_we && !load_reset && !rstdone_clr)
        |=> st_q.stat[SB_RST] == $past(st_q.stat[SB_RST]));
    // R8: the reset port reloads the status byte
    p_reset_port_r8: assert property (@(posedge clk) disable iff (rst)
        load_reset |=> st_q.stat == STAT_AT_RESET);
    // R9: set events win over clears
    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (set_bits != '0 && !load_reset)
        |=> (st_q.stat[6:0] & $past(set_bits)) == $past(set_bits));
endmodule

// File: rtl/ctl_bank1.sv
module ctl_bank1
    import ctl_pkg::*;
#(
    parameter int STA_BYTES  = 6,
    parameter int HASH_BYTES = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [OFF_W-1:0]          off,
    input  logic [DATA_W-1:0]         wdata,
    input  logic                      rx_page_we,
    input  logic [DATA_W-1:0]         rx_page,
    output logic [DATA_W-1:0]         rd_byte,
    output logic [8*STA_BYTES-1:0]    sta_addr_o,
    output logic [8*HASH_BYTES-1:0]   hash_o,
    output logic [DATA_W-1:0]         cur_page_o
);
    localparam int NREG     = STA_BYTES + 1 + HASH_BYTES;
    localparam int CUR_IDX  = STA_BYTES;
    localparam int HASH_IDX = STA_BYTES + 1;

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] bytes;
    } b1_st_t;

    b1_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        rd_byte = '0;
        for (int i = 0; i < NREG; i++) begin
            if (we && off == OFF_W'(i + 1))
                st_d.bytes[i] = wdata;
            if (off == OFF_W'(i + 1))
                rd_byte = st_q.bytes[i];
        end
        if (rx_page_we)
            st_d.bytes[CUR_IDX] = rx_page;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    for (genvar g = 0; g < STA_BYTES; g++) begin : g_sta
        assign sta_addr_o[8*g +: 8] = st_q.bytes[g];
    end
    for (genvar h = 0; h < HASH_BYTES; h++) begin : g_hash
        assign hash_o[8*h +: 8] = st_q.bytes[HASH_IDX + h];
    end
    assign cur_page_o = st_q.bytes[CUR_IDX];

    // R11: a receive-side page update always lands
    p_rxpage_r11: assert property (@(posedge clk) disable iff (rst)
        rx_page_we |=> cur_page_o == $past(rx_page));
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
    import ctl_pkg::*;
#(
    parameter int STA_BYTES  = 6,
    parameter int HASH_BYTES = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [3:0]              bus_addr,
    input  logic [7:0]              bus_wdata,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    output logic [7:0]              bus_rdata,
    input  logic                    rst_port_rd,
    output logic                    irq,
    output logic                    tx_req,
    output logic [7:0]              tx_page,
    output logic [15:0]             tx_count,
    output logic [15:0]             rdma_count,
    output logic                    rdma_rd,
    output logic                    rdma_wr,
    input  logic [6:0]              evt_set,
    input  logic                    rx_page_we,
    input  logic [7:0]              rx_page,
    output logic [8*STA_BYTES-1:0]  sta_addr,
    output logic [8*HASH_BYTES-1:0] mcast_hash,
    output logic [7:0]              cur_page
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } top_st_t;

    top_st_t           st_d, st_q;
    logic [DATA_W-1:0] cmd_w, tsr_w, stat_w, b1_byte;
    logic              rdc_set, txok_set, rstdone_clr;
    logic              cmd_we, b0_we, b1_we;
    bank_e             bank;
    logic [6:0]        set_all;

    always_comb begin
        bank   = bank_e'(cmd_w[7:6]);
        cmd_we = bus_wr && (bus_addr == '0);
        b0_we  = bus_wr && (bus_addr != '0) && (bank == BANK_CTRL);
        b1_we  = bus_wr && (bus_addr != '0) && (bank == BANK_ADDR);
        set_all = evt_set;
        set_all[SB_RDC]  = set_all[SB_RDC]  | rdc_set;
        set_all[SB_TXOK] = set_all[SB_TXOK] | txok_set;
    end

    ctl_cmd u_cmd (
        .clk          (clk),
        .rst          (rst),
        .cmd_we       (cmd_we),
        .b0_we        (b0_we),
        .b0_off       (bus_addr),
        .wdata        (bus_wdata),
        .cmd_o        (cmd_w),
        .tsr_o        (tsr_w),
        .tx_req_o     (tx_req),
        .tx_page_o    (tx_page),
        .tx_count_o   (tx_count),
        .rcount_o     (rdma_count),
        .rdc_set_o    (rdc_set),
        .txok_set_o   (txok_set),
        .rstdone_clr_o(rstdone_clr)
    );

    ctl_irq u_irq (
        .clk        (clk),
        .rst        (rst),
        .stat_we    (b0_we && bus_addr == B0_STAT),
        .mask_we    (b0_we && bus_addr == B0_MASK),
        .wdata      (bus_wdata),
        .set_bits   (set_all),
        .rstdone_clr(rstdone_clr),
        .load_reset (rst_port_rd),
        .stat_o     (stat_w),
        .irq_o      (irq)
    );

    ctl_bank1 #(
        .STA_BYTES (STA_BYTES),
        .HASH_BYTES(HASH_BYTES)
    ) u_bank1 (
        .clk        (clk),
        .rst        (rst),
        .we         (b1_we),
        .off        (bus_addr),
        .wdata      (bus_wdata),
        .rx_page_we (rx_page_we),
        .rx_page    (rx_page),
        .rd_byte    (b1_byte),
        .sta_addr_o (sta_addr),
        .hash_o     (mcast_hash),
        .cur_page_o (cur_page)
    );

    always_comb begin
        st_d = st_q;
        if (bus_rd) begin
            st_d.rdata = '0;
            if (bus_addr == '0) begin
                st_d.rdata = cmd_w;
            end else begin
                unique case (bank)
                    BANK_CTRL: begin
                        if (bus_addr == B0_TXPG) st_d.rdata = tsr_w;
                        if (bus_addr == B0_STAT) st_d.rdata = stat_w;
                    end
                    BANK_ADDR: st_d.rdata = b1_byte;
                    default:   st_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign rdma_rd   = cmd_w[CB_RRD];
    assign rdma_wr   = cmd_w[CB_RWR];

    // R10: read data holds between read strobes
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/ctl_regbank_tb.sv
module ctl_regbank_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_wr, bus_rd, rst_port_rd, rx_page_we;
    logic [7:0]  bus_rdata, tx_page, rx_page, cur_page;
    logic        irq, tx_req, rdma_rd, rdma_wr;
    logic [15:0] tx_count, rdma_count;
    logic [6:0]  evt_set;
    logic [47:0] sta_addr;
    logic [63:0] mcast_hash;

    int checks = 0;
    int errors = 0;

    // reference model
    logic [7:0]  m_cmd, m_stat, m_mask, m_tsr, m_tpg;
    logic [15:0] m_tcnt, m_rcnt;
    logic [7:0]  m_b1 [16];

    always #5 clk = ~clk;

    ctl_regbank dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .rst_port_rd(rst_port_rd), .irq(irq), .tx_req(tx_req),
        .tx_page(tx_page), .tx_count(tx_count), .rdma_count(rdma_count),
        .rdma_rd(rdma_rd), .rdma_wr(rdma_wr), .evt_set(evt_set),
        .rx_page_we(rx_page_we), .rx_page(rx_page), .sta_addr(sta_addr),
        .mcast_hash(mcast_hash), .cur_page(cur_page)
    );

    function automatic logic exp_irq();
        return |(m_stat & m_mask & 8'h7F);
    endfunction

    function automatic logic [7:0] exp_read(input logic [3:0] a);
        if (a == 4'h0) return m_cmd;
        case (m_cmd[7:6])
            2'd0: begin
                if (a == 4'h4) return m_tsr;
                if (a == 4'h7) return m_stat;
                return 8'h00;
            end
            2'd1: return m_b1[a];
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        logic        do_tx;
        logic [7:0]  e_pg;
        logic [15:0] e_cnt;
        do_tx = 1'b0;
        e_pg  = m_tpg;
        e_cnt = m_tcnt;
        if (a == 4'h0) begin
            m_cmd = d;
            if (!d[0]) begin
                m_stat[7] = 1'b0;
                if ((d[3] || d[4]) && m_rcnt == 16'h0) m_stat[6] = 1'b1;
                if (d[2]) begin
                    do_tx = 1'b1;
                    m_tsr = 8'h01;
                    m_stat[1] = 1'b1;
                    m_cmd[2] = 1'b0;
                end
            end
        end else if (m_cmd[7:6] == 2'd0) begin
            case (a)
                4'h4: m_tpg = d;
                4'h5: m_tcnt[7:0] = d;
                4'h6: m_tcnt[15:8] = d;
                4'h7: m_stat[6:0] = m_stat[6:0] & ~d[6:0];
                4'hA: m_rcnt[7:0] = d;
                4'hB: m_rcnt[15:8] = d;
                4'hF: m_mask = d;
                default: ;
            endcase
        end else if (m_cmd[7:6] == 2'd1) begin
            m_b1[a] = d;
        end
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check(64'(irq), 64'(exp_irq()), "R4");
        check(64'(tx_req), 64'(do_tx), "R7");
        if (do_tx) begin
            check(64'(tx_page), 64'(e_pg), "R7");
            check(64'(tx_count), 64'(e_cnt), "R7");
            @(negedge clk);
            check(64'(tx_req), 64'd0, "R7");
        end
    endtask

    task automatic rd(input logic [3:0] a, input string req);
        logic [7:0] e;
        @(negedge clk);
        e = exp_read(a);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check(64'(bus_rdata), 64'(e), req);
    endtask

    task automatic clr_and_set(input logic [6:0] clr, input logic [6:0] setb);
        // bank 0 assumed selected
        m_stat[6:0] = (m_stat[6:0] & ~clr) | setb;
        @(negedge clk);
        bus_addr = 4'h7; bus_wdata = {1'b0, clr}; bus_wr = 1'b1; evt_set = setb;
        @(negedge clk);
        bus_wr = 1'b0; evt_set = '0;
        check(64'(irq), 64'(exp_irq()), "R9");
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL R10 watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd2718);
        rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        rst_port_rd = 1'b0; rx_page_we = 1'b0; rx_page = '0; evt_set = '0;
        m_cmd = 8'h01; m_stat = 8'h80; m_mask = '0; m_tsr = '0; m_tpg = '0;
        m_tcnt = '0; m_rcnt = '0;
        for (int i = 0; i < 16; i++) m_b1[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(64'(irq), 64'd0, "R1");
        check(64'(tx_req), 64'd0, "R1");
        rd(4'h0, "R1");
        rd(4'h7, "R1");
        rd(4'h4, "R1");

        // R4: reset-done alone with all enables on keeps irq low
        wr(4'hF, 8'hFF);
        check(64'(irq), 64'd0, "R4");

        // R5: stop set keeps bit 7, stop clear drops it
        wr(4'h0, 8'h01);
        rd(4'h7, "R5");
        wr(4'h0, 8'h02);
        rd(4'h7, "R5");

        // R6: remote read with zero count
        wr(4'h0, 8'h0A);
        rd(4'h7, "R6");
        check(64'(irq), 64'd1, "R6");
        // R3: clear all low bits, bit 7 stays as is
        wr(4'h7, 8'hFF);
        rd(4'h7, "R3");
        // R6: nonzero count does not set the bit
        wr(4'hA, 8'h03);
        check(64'(rdma_count), 64'h0003, "R6");
        wr(4'h0, 8'h12);
        rd(4'h7, "R6");

        // R7: transmit
        wr(4'h4, 8'h46); wr(4'h5, 8'h3C); wr(4'h6, 8'h05);
        wr(4'h0, 8'h06);
        rd(4'h0, "R7");
        rd(4'h4, "R7");
        rd(4'h7, "R7");
        // R7: transmit bit with stop set does nothing
        wr(4'h0, 8'h05);

        // R9: set wins over clear
        wr(4'h0, 8'h02);
        clr_and_set(7'h7F, 7'h05);
        rd(4'h7, "R9");

        // R8: reset port
        @(negedge clk); rst_port_rd = 1'b1;
        m_stat = 8'h80;
        @(negedge clk); rst_port_rd = 1'b0;
        rd(4'h7, "R8");
        check(64'(irq), 64'd0, "R8");

        // R2: bank 3 ignores writes, reads zero
        wr(4'h0, 8'hC2);
        wr(4'h7, 8'h7F);
        rd(4'h7, "R2");
        rd(4'h3, "R2");
        wr(4'h0, 8'h82);
        rd(4'h9, "R2");
        wr(4'h0, 8'h02);
        rd(4'h7, "R2");
        rd(4'hF, "R2");

        // R11: bank 1 storage and receive-side page
        wr(4'h0, 8'h42);
        for (int a = 1; a < 16; a++) wr(4'(a), 8'(8'h10 * a + 8'h3));
        for (int a = 1; a < 16; a++) rd(4'(a), "R11");
        check(64'(sta_addr), {16'h0, m_b1[6], m_b1[5], m_b1[4], m_b1[3], m_b1[2], m_b1[1]}, "R11");
        check(64'(mcast_hash), {m_b1[15], m_b1[14], m_b1[13], m_b1[12],
                                m_b1[11], m_b1[10], m_b1[9], m_b1[8]}, "R11");
        @(negedge clk);
        bus_addr = 4'h7; bus_wdata = 8'hEE; bus_wr = 1'b1;
        rx_page_we = 1'b1; rx_page = 8'h5A; m_b1[7] = 8'h5A;
        @(negedge clk);
        bus_wr = 1'b0; rx_page_we = 1'b0;
        check(64'(cur_page), 64'h5A, "R11");
        rd(4'h7, "R11");

        // random phase
        for (int n = 0; n < 400; n++) begin
            int unsigned op;
            op = $urandom_range(0, 5);
            case (op)
                0: wr(4'h0, {2'($urandom_range(0, 3)), 6'($urandom)});
                1: wr(4'($urandom_range(1, 15)), 8'($urandom));
                2: rd(4'($urandom_range(0, 15)), "R2");
                3: begin
                    if (m_cmd[7:6] == 2'd0) clr_and_set(7'($urandom), 7'($urandom));
                    else rd(4'h0, "R10");
                end
                4: begin
                    logic [6:0] ev;
                    ev = 7'($urandom);
                    m_stat[6:0] = m_stat[6:0] | ev;
                    @(negedge clk); evt_set = ev;
                    @(negedge clk); evt_set = '0;
                    check(64'(irq), 64'(exp_irq()), "R9");
                end
                default: begin
                    logic [7:0] pg;
                    pg = 8'($urandom);
                    m_b1[7] = pg;
                    @(negedge clk); rx_page_we = 1'b1; rx_page = pg;
                    @(negedge clk); rx_page_we = 1'b0;
                    check(64'(cur_page), 64'(pg), "R11");
                end
            endcase
        end
        wr(4'h0, 8'h02);
        rd(4'h7, "R3");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule